// File: doc/BRIEF.md
# Debug Trigger Sequencer

This block is a small state machine that turns single-cycle match pulses from three comparator channels (M0, M1, M2) into a debug trigger. It steps through three intermediate states and a terminal firing state. A 4-bit control word for each intermediate state sets which match moves the sequencer and where it goes. With these words, software can express orderings such as "M2 then either M0 or M1", "two M2 events then M0, with M1 starting over", or "a repeat of M0/M1 with no M2 in between".

Each control word names one watched event and its destination. The same word also implies one fixed secondary route, so a state can fork: one match leads toward the trigger and another leads elsewhere, or a designated event returns the sequencer to the first state. When several channels match in the same cycle, only the lowest-numbered one is considered. After the firing state is reached, the trigger stays high and every match is ignored until the sequencer is armed again.

Top module: `dbg_trig_seq`

## Requirements
- R1: After synchronous reset, `state_o` is 0 (first state) and `trig_o` is 0. Until the first `arm_i` pulse, matches cause no transition.
- R2: An `arm_i` pulse makes the next edge load the first state and clear `trig_o`. It also enables evaluation. Matches present in the same cycle as `arm_i` are ignored.
- R3: State codes are 0 = first, 1 = second, 2 = third, 3 = firing. A match in cycle N changes `state_o` at the rising edge that ends cycle N. At most one transition happens per cycle, and a cycle with no match leaves the state unchanged.
- R4: Control word bits [1:0] select the watched event: 0 = none (the state holds), 1 = M0 or M1, 2 = M1, 3 = M2. Bits [3:2] give its destination state code. A winning match that has no route leaves the state unchanged.
- R5: Secondary routes are fixed by the event select. With select 2, M0 goes to the firing state. With select 3, M1 goes to the first state. With select 1, M2 goes to the first state.
- R6: When several bits of `match_i` are set in one cycle, only the lowest-numbered set channel decides the transition, even when that channel has no route.
- R7: `trig_o` rises on the same edge that `state_o` becomes 3. Both then hold, whatever the matches, until `arm_i`.
- R8: The word used is the one for the current state: `ctl1_i` in state 0, `ctl2_i` in state 1 and `ctl3_i` in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm/rearm pulse |
| match_i | input | 3 | Match pulses; bit k is channel Mk |
| ctl1_i | input | 4 | Control word of the first state |
| ctl2_i | input | 4 | Control word of the second state |
| ctl3_i | input | 4 | Control word of the third state |
| state_o | output | 2 | Current state code (registered) |
| trig_o | output | 1 | Trigger flag (registered) |

## Verification
Both outputs are registered, and each is due exactly one rising edge after the cycle that carries the match or arm pulse. There is no further pipeline stage. The bench drives every input on the falling edge and samples 2 ns after the next rising edge. In this way, each vector's expected state and trigger belong to the single edge that consumed that vector. The vector table walks each scenario one cycle at a time, including same-cycle multi-channel matches. Directed tests then cover reset, the unarmed state and the firing hold.

// File: rtl/dbg_trig_seq_pkg.sv
package dbg_trig_seq_pkg;
  localparam int CH_N  = 3;   // comparator channels
  localparam int CH_W  = 2;   // channel index width
  localparam int CTL_W = 4;   // control word width
  localparam int ST_W  = 2;   // state code width
  localparam int STG_N = 3;   // intermediate states

  typedef enum logic [1:0] {
    ST_S1  = 2'd0,
    ST_S2  = 2'd1,
    ST_S3  = 2'd2,
    ST_FIN = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_M01  = 2'd1,
    EV_M1   = 2'd2,
    EV_M2   = 2'd3
  } ev_sel_t;

  // One table entry: {take, next state} for control code and winning channel.
  function automatic logic [ST_W:0] route_entry(input logic [CTL_W-1:0] code, input int ch);
    logic [ST_W-1:0] dst;
    logic            take;
    logic [ST_W-1:0] nxt;
    dst  = code[3:2];
    take = 1'b0;
    nxt  = ST_S1;
    case (ev_sel_t'(code[1:0]))
      EV_M01: begin
        if (ch == 0 || ch == 1) begin take = 1'b1; nxt = dst;   end
        else if (ch == 2)       begin take = 1'b1; nxt = ST_S1; end
      end
      EV_M1: begin
        if (ch == 1)      begin take = 1'b1; nxt = dst;    end
        else if (ch == 0) begin take = 1'b1; nxt = ST_FIN; end
      end
      EV_M2: begin
        if (ch == 2)      begin take = 1'b1; nxt = dst;   end
        else if (ch == 1) begin take = 1'b1; nxt = ST_S1; end
      end
      default: begin take = 1'b0; nxt = ST_S1; end
    endcase
    return {take, nxt};
  endfunction
endpackage

// File: rtl/dbg_trig_prio.sv
module dbg_trig_prio
  import dbg_trig_seq_pkg::*;
#(
  parameter int N  = CH_N,
  parameter int IW = CH_W
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  // lowest set channel wins
  always_comb begin
    idx_o = '0;
    vld_o = |req_i;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end

  always_comb begin
    if (vld_o) begin
      assert_lowest_wins_R6: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/dbg_trig_rules.sv
module dbg_trig_rules
  import dbg_trig_seq_pkg::*;
#(
  parameter int CW = CTL_W,
  parameter int IW = CH_W,
  parameter int SW = ST_W
) (
  input  logic [CW-1:0] ctl_i,
  input  logic [IW-1:0] win_i,
  input  logic          win_vld_i,
  output logic          take_o,
  output logic [SW-1:0] dst_o
);
  localparam int NCODE = 1 << CW;
  localparam int NSLOT = 1 << IW;

  // full lookup: every control code against every channel slot
  logic [SW:0] tbl [NCODE][NSLOT];

  generate
    for (genvar c = 0; c < NCODE; c++) begin : g_code
      for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        if (k < CH_N) begin : g_live
          assign tbl[c][k] = (SW+1)'(route_entry(CTL_W'(c), k));
        end else begin : g_pad
          assign tbl[c][k] = '0;
        end
      end
    end
  endgenerate

  logic [SW:0] hit;
  assign hit    = tbl[ctl_i][win_i];
  assign take_o = win_vld_i & hit[SW];
  assign dst_o  = hit[SW-1:0];
endmodule

// File: rtl/dbg_trig_core.sv
module dbg_trig_core
  import dbg_trig_seq_pkg::*;
#(
  parameter int SW = ST_W,
  parameter int SN = STG_N
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  arm_i,
  input  logic [SN-1:0]         take_v_i,
  input  logic [SN-1:0][SW-1:0] dst_v_i,
  input  logic [SN-1:0]         idle_v_i,
  output logic [SW-1:0]         state_o,
  output logic                  trig_o
);
  logic [SW-1:0] state_q;
  logic          trig_q;
  logic          armed_q;
  logic          take_c;
  logic [SW-1:0] dst_c;
  logic          idle_c;

  // pick the rule outputs of the current state
  always_comb begin
    take_c = 1'b0;
    dst_c  = state_q;
    idle_c = 1'b0;
    for (int s = 0; s < SN; s++) begin
      if (state_q == SW'(s)) begin
        take_c = take_v_i[s];
        dst_c  = dst_v_i[s];
        idle_c = idle_v_i[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_S1;
      trig_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      state_q <= ST_S1;
      trig_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (armed_q && take_c) begin
      state_q <= dst_c;
      trig_q  <= (dst_c == ST_FIN);
    end
  end

  assign state_o = state_q;
  assign trig_o  = trig_q;

  assert_unarmed_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !arm_i) |=> (state_q == ST_S1 && !trig_q));

  assert_arm_restart_R2: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (state_q == ST_S1 && !trig_q));

  assert_none_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !arm_i && state_q != ST_FIN && idle_c) |=> $stable(state_q));

  assert_final_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN && !arm_i) |=> (state_q == ST_FIN && trig_q));

  assert_trig_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    trig_q == (state_q == ST_FIN));
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                arm_i,
  input  logic [CH_N-1:0]     match_i,
  input  logic [CTL_W-1:0]    ctl1_i,
  input  logic [CTL_W-1:0]    ctl2_i,
  input  logic [CTL_W-1:0]    ctl3_i,
  output logic [ST_W-1:0]     state_o,
  output logic                trig_o
);
  logic [STG_N-1:0][CTL_W-1:0] ctl_v;
  logic [CH_W-1:0]             win_idx;
  logic                        win_vld;
  logic [STG_N-1:0]            take_v;
  logic [STG_N-1:0][ST_W-1:0]  dst_v;
  logic [STG_N-1:0]            idle_v;

  assign ctl_v = {ctl3_i, ctl2_i, ctl1_i};

  dbg_trig_prio #(.N(CH_N), .IW(CH_W)) u_prio (
    .req_i (match_i),
    .idx_o (win_idx),
    .vld_o (win_vld)
  );

  generate
    for (genvar s = 0; s < STG_N; s++) begin : g_stage
      dbg_trig_rules #(.CW(CTL_W), .IW(CH_W), .SW(ST_W)) u_rules (
        .ctl_i     (ctl_v[s]),
        .win_i     (win_idx),
        .win_vld_i (win_vld),
        .take_o    (take_v[s]),
        .dst_o     (dst_v[s])
      );
      assign idle_v[s] = (ctl_v[s][1:0] == EV_NONE);
    end
  endgenerate

  dbg_trig_core #(.SW(ST_W), .SN(STG_N)) u_core (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_i),
    .take_v_i (take_v),
    .dst_v_i  (dst_v),
    .idle_v_i (idle_v),
    .state_o  (state_o),
    .trig_o   (trig_o)
  );
endmodule

// File: tb/dbg_trig_seq_test.sv
module dbg_trig_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm_i = 1'b0;
  logic [2:0] match_i = 3'b000;
  logic [3:0] ctl1_i = 4'd0, ctl2_i = 4'd0, ctl3_i = 4'd0;
  logic [1:0] state_o;
  logic       trig_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_trig_seq uut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .match_i(match_i),
    .ctl1_i(ctl1_i), .ctl2_i(ctl2_i), .ctl3_i(ctl3_i),
    .state_o(state_o), .trig_o(trig_o)
  );

  // {arm, match[2:0], ctl1, ctl2, ctl3, exp_state, exp_trig}
  localparam int NV = 33;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 3'b000, 4'd6,  4'd0,  4'd0, 2'd0, 1'b0},
    {1'b0, 3'b011, 4'd6,  4'd0,  4'd0, 2'd3, 1'b1},
    {1'b0, 3'b100, 4'd6,  4'd0,  4'd0, 2'd3, 1'b1},
    {1'b1, 3'b000, 4'd6,  4'd0,  4'd0, 2'd0, 1'b0},
    {1'b0, 3'b110, 4'd6,  4'd0,  4'd0, 2'd1, 1'b0},
    {1'b0, 3'b111, 4'd6,  4'd0,  4'd0, 2'd1, 1'b0},
    {1'b1, 3'b000, 4'd6,  4'd0,  4'd0, 2'd0, 1'b0},
    {1'b0, 3'b100, 4'd6,  4'd0,  4'd0, 2'd0, 1'b0},
    {1'b1, 3'b000, 4'd7,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b001, 4'd7,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd13, 4'd0, 2'd1, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd13, 4'd0, 2'd1, 1'b0},
    {1'b0, 3'b010, 4'd7,  4'd13, 4'd0, 2'd3, 1'b1},
    {1'b1, 3'b000, 4'd7,  4'd11, 4'd2, 2'd0, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd11, 4'd2, 2'd1, 1'b0},
    {1'b0, 3'b010, 4'd7,  4'd11, 4'd2, 2'd0, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd11, 4'd2, 2'd1, 1'b0},
    {1'b0, 3'b001, 4'd7,  4'd11, 4'd2, 2'd1, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd11, 4'd2, 2'd2, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd11, 4'd2, 2'd2, 1'b0},
    {1'b0, 3'b010, 4'd7,  4'd11, 4'd2, 2'd0, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd11, 4'd2, 2'd1, 1'b0},
    {1'b0, 3'b100, 4'd7,  4'd11, 4'd2, 2'd2, 1'b0},
    {1'b0, 3'b011, 4'd7,  4'd11, 4'd2, 2'd3, 1'b1},
    {1'b1, 3'b000, 4'd5,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b010, 4'd5,  4'd13, 4'd0, 2'd1, 1'b0},
    {1'b0, 3'b100, 4'd5,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b001, 4'd5,  4'd13, 4'd0, 2'd1, 1'b0},
    {1'b0, 3'b001, 4'd5,  4'd13, 4'd0, 2'd3, 1'b1},
    {1'b1, 3'b001, 4'd5,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b000, 4'd5,  4'd13, 4'd0, 2'd0, 1'b0},
    {1'b0, 3'b001, 4'd0,  4'd13, 4'd0, 2'd0, 1'b0}
  };

  localparam string VTAG [NV] = '{
    "R2", "R6", "R7", "R2", "R6", "R4", "R2", "R4",
    "R2", "R4", "R4", "R5", "R4", "R7", "R2", "R4",
    "R5", "R4", "R6", "R8", "R4", "R4", "R4", "R8",
    "R5", "R2", "R4", "R5", "R4", "R4", "R2", "R3",
    "R8"
  };

  task automatic check(input string req, input logic [1:0] es, input logic et);
    checks++;
    if (state_o !== es || trig_o !== et) begin
      errors++;
      $display("FAIL %s: state=%0d trig=%0b expected state=%0d trig=%0b",
               req, state_o, trig_o, es, et);
    end
  endtask

  task automatic step(input logic a, input logic [2:0] m);
    @(negedge clk);
    arm_i = a;
    match_i = m;
    @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(posedge clk);
    #2;
    check("R1 reset", 2'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      arm_i   = VEC[i][18];
      match_i = VEC[i][17:15];
      ctl1_i  = VEC[i][14:11];
      ctl2_i  = VEC[i][10:7];
      ctl3_i  = VEC[i][6:3];
      @(posedge clk);
      #2;
      check(VTAG[i], VEC[i][2:1], VEC[i][0]);
    end

    // R1: reset mid-run, then matches ignored while unarmed
    @(negedge clk);
    arm_i = 1'b0; match_i = 3'b000; rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset mid-run", 2'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    ctl1_i = 4'd5; ctl2_i = 4'd13; ctl3_i = 4'd0;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 3'b001);
      check("R1 unarmed", 2'd0, 1'b0);
    end
    step(1'b1, 3'b000);
    check("R2 arm", 2'd0, 1'b0);
    step(1'b0, 3'b001);
    check("R2 armed moves", 2'd1, 1'b0);
    step(1'b0, 3'b010);
    check("R7 fire", 2'd3, 1'b1);
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 3'(k));
      check("R7 hold", 2'd3, 1'b1);
    end

    // R6: M0 with M2 under select M2 -> M0 decides, no route, hold
    ctl1_i = 4'd7;
    step(1'b1, 3'b000);
    check("R2 rearm", 2'd0, 1'b0);
    step(1'b0, 3'b101);
    check("R6 M0 blocks M2", 2'd0, 1'b0);
    step(1'b0, 3'b000);
    check("R3 no match holds", 2'd0, 1'b0);
    step(1'b0, 3'b100);
    check("R3 one edge", 2'd1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule